// File: doc/BRIEF.md
# Single-Cycle Integer Core (RV32I subset)

This block is a single-cycle processor core for a subset of the RISC-V integer instruction set. It runs register-register arithmetic, immediate arithmetic, word loads and stores, and the four conditional branches equal, not-equal, signed less-than and signed greater-or-equal. Each instruction completes in one clock period. The program counter, a 32-entry register file, the ALU, immediate extraction, the main decode and one dual-port word-addressed memory all sit inside the core. One memory port fetches instructions and the other serves loads and stores.

Instruction fetch, register writeback and the program-counter update all take place on the rising clock edge. The data port runs on the inverted clock. A load therefore reads memory at the falling edge in the middle of its own cycle, and its result is written back at the next rising edge, while the following instruction is fetched. The register file reads asynchronously. Byte addresses from the PC or the ALU are shifted right by two to form word indices, and only the low address bits the memory holds are applied.

While reset is held, a preload path writes words into memory. This is how a program and its data are placed in memory. A set of observation outputs exposes the current PC and the register write that will commit at the end of the current cycle. The core has no streaming interface. All of its pins are plain control, preload and observation signals.

Top module: `sc_core`

## Requirements
- R1: A synchronous reset sets the PC to 0 and clears all 32 registers. While reset is high, no register write is reported and the core makes no store. After reset is released, the first instruction executed is the word at byte address 0.
- R2: Register-register operations (opcode 0110011) compute add, sub, sll, slt, sltu, xor, srl, sra, or and and, selected by funct3. Instruction bit 30 selects sub in place of add, and sra in place of srl. Shift amounts use the low 5 bits of the second operand.
- R3: Immediate operations (opcode 0010011) use the 12-bit immediate in bits 31:20, sign-extended, as the second operand. For addi, bit 30 is ignored. For shift-right, bit 30 selects arithmetic (srai) in place of logical.
- R4: A write to x0 is discarded and no register write is reported for it. x0 always reads as zero.
- R5: lw (opcode 0000011) writes the word at byte address rs1 + sign-extended I-immediate to rd.
- R6: sw (opcode 0100011) stores rs2 at byte address rs1 + sign-extended S-immediate, formed from bits 31:25 and 11:7. A store never writes the register file.
- R7: The memory word index is the byte address shifted right by 2, truncated to its low AW bits (10 by default). Higher address bits are discarded, so byte address 0x1400 aliases to byte address 0x400.
- R8: Branches (opcode 1100011) with funct3 000 (eq), 001 (ne), 100 (signed lt) and 101 (signed ge) compare rs1 with rs2. When the condition holds, the next PC is PC + the B-immediate, whose lowest bit is an implicit zero.
- R9: Every non-branch instruction, a branch not taken, and a branch with any other funct3 advance the PC by 4.
- R10: An instruction with an unrecognised opcode writes no register and no memory, and advances the PC by 4.
- R11: The preload port writes load_data to word load_addr only while reset is high. When reset is low, the preload port has no effect.
- R12: A load result is written back at the rising edge that ends the load's cycle, so the very next instruction can read the loaded register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the data port uses its inverse |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Preload write strobe, honoured only in reset |
| load_addr | input | AW | Preload word index |
| load_data | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter (byte address) |
| wb_en_o | output | 1 | A register write to a nonzero register commits at the next rising edge |
| wb_rd_o | output | 5 | Destination register of that write |
| wb_data_o | output | 32 | Value of that write |

## Verification
The embedded properties check on every cycle that x0 stays zero, that a register write lands with the value presented, that a store and a register write are never decoded together, and that the PC follows its rules. The PC must be 0 on leaving reset, must advance by 4 for sequential flow and must reach PC + offset for a taken branch. Only the bench scenarios can show the results of the computation. These include the value of each ALU function, signed against unsigned comparison, address aliasing above the memory size, a store followed by a load of the same word, a load whose result is used by the very next instruction, and the preload port being ignored outside reset.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;
  localparam int XLEN = 32;

  localparam logic [6:0] OPC_ARITH  = 7'b0110011;
  localparam logic [6:0] OPC_ARITHI = 7'b0010011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;

  typedef enum logic [3:0] {
    FN_ADD, FN_SUB, FN_SLL, FN_SLT, FN_SLTU,
    FN_XOR, FN_SRL, FN_SRA, FN_OR,  FN_AND
  } alu_fn_e;

  // 2-bit ALU operation class produced by the main decode
  localparam logic [1:0] AOP_MEM   = 2'b00;
  localparam logic [1:0] AOP_BR    = 2'b01;
  localparam logic [1:0] AOP_ARITH = 2'b10;

  typedef struct packed {
    logic       reg_we;
    logic       mem_we;
    logic       use_imm;
    logic       wb_from_mem;
    logic       is_branch;
    logic [1:0] aop;
  } ctl_t;
endpackage

// File: rtl/sc_decode.sv
`timescale 1ns/1ps
module sc_decode
  import sc_pkg::*;
(
  input  logic [XLEN-1:0] inst,
  output ctl_t            ctl,
  output alu_fn_e         fn,
  output logic [XLEN-1:0] imm
);
  logic [6:0] opc;
  logic [2:0] f3;
  assign opc = inst[6:0];
  assign f3  = inst[14:12];

  // main decode
  always_comb begin
    ctl = '0;
    ctl.aop = AOP_MEM;
    unique case (opc)
      OPC_ARITH:  begin ctl.reg_we = 1'b1; ctl.aop = AOP_ARITH; end
      OPC_ARITHI: begin ctl.reg_we = 1'b1; ctl.use_imm = 1'b1; ctl.aop = AOP_ARITH; end
      OPC_LOAD:   begin ctl.reg_we = 1'b1; ctl.use_imm = 1'b1; ctl.wb_from_mem = 1'b1; end
      OPC_STORE:  begin ctl.mem_we = 1'b1; ctl.use_imm = 1'b1; end
      OPC_BRANCH: begin ctl.is_branch = 1'b1; ctl.aop = AOP_BR; end
      default:    ;
    endcase
  end

  // ALU function select
  always_comb begin
    fn = FN_ADD;
    case (ctl.aop)
      AOP_BR:    fn = FN_SUB;
      AOP_ARITH: begin
        case (f3)
          3'b000:  fn = (opc == OPC_ARITH && inst[30]) ? FN_SUB : FN_ADD;
          3'b001:  fn = FN_SLL;
          3'b010:  fn = FN_SLT;
          3'b011:  fn = FN_SLTU;
          3'b100:  fn = FN_XOR;
          3'b101:  fn = inst[30] ? FN_SRA : FN_SRL;
          3'b110:  fn = FN_OR;
          default: fn = FN_AND;
        endcase
      end
      default:   fn = FN_ADD;
    endcase
  end

  // immediate extraction, sign-extended per format
  always_comb begin
    case (opc)
      OPC_ARITHI, OPC_LOAD:
        imm = {{(XLEN-12){inst[31]}}, inst[31:20]};
      OPC_STORE:
        imm = {{(XLEN-12){inst[31]}}, inst[31:25], inst[11:7]};
      OPC_BRANCH:
        imm = {{(XLEN-13){inst[31]}}, inst[31], inst[7], inst[30:25], inst[11:8], 1'b0};
      default:
        imm = '0;
    endcase
  end

  // a store must never be decoded together with a register write (R6)
  always_comb begin
    p_store_no_wb_r6: assert (!(ctl.mem_we && ctl.reg_we));
  end
endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wa,
  input  logic [W-1:0]            wd,
  input  logic [$clog2(NREG)-1:0] ra1,
  input  logic [$clog2(NREG)-1:0] ra2,
  output logic [W-1:0]            rd1,
  output logic [W-1:0]            rd2
);
  localparam int IW = $clog2(NREG);

  logic [NREG-1:0][W-1:0] q;

  // entry 0 is never written, so it holds the reset value zero
  always_ff @(posedge clk) begin
    if (rst)                  q <= '0;
    else if (we && wa != '0)  q[wa] <= wd;
  end

  assign rd1 = q[ra1];
  assign rd2 = q[ra2];

  p_x0_zero_r4: assert property (@(posedge clk) disable iff (rst)
    q[0] == '0);

  p_write_lands_r5: assert property (@(posedge clk) disable iff (rst)
    (we && wa != IW'(0)) |=> q[$past(wa)] == $past(wd));
endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
  import sc_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_fn_e         fn,
  output logic [XLEN-1:0] y
);
  localparam int SHW = $clog2(XLEN);
  logic [SHW-1:0] sh;
  assign sh = b[SHW-1:0];

  always_comb begin
    case (fn)
      FN_ADD:  y = a + b;
      FN_SUB:  y = a - b;
      FN_SLL:  y = a << sh;
      FN_SLT:  y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      FN_SLTU: y = {{(XLEN-1){1'b0}}, (a < b)};
      FN_XOR:  y = a ^ b;
      FN_SRL:  y = a >> sh;
      FN_SRA:  y = XLEN'($signed(a) >>> sh);
      FN_OR:   y = a | b;
      FN_AND:  y = a & b;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/sc_mem.sv
`timescale 1ns/1ps
module sc_mem #(
  parameter int AW = 10,
  parameter int W  = 32
) (
  input  logic          clk,
  // fetch side, rising edge
  input  logic [AW-1:0] a_addr,
  output logic [W-1:0]  a_rdata,
  // data side, falling edge (inverted clock)
  input  logic [AW-1:0] b_addr,
  input  logic          b_we,
  input  logic [W-1:0]  b_wdata,
  output logic [W-1:0]  b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    a_rdata <= mem[a_addr];
  end

  always_ff @(negedge clk) begin
    if (b_we) mem[b_addr] <= b_wdata;
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
  import sc_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_en,
  input  logic [AW-1:0]   load_addr,
  input  logic [31:0]     load_data,
  output logic [31:0]     pc_o,
  output logic            wb_en_o,
  output logic [4:0]      wb_rd_o,
  output logic [31:0]     wb_data_o
);
  localparam int NREG = 32;
  localparam int RW   = $clog2(NREG);

  logic [XLEN-1:0] pc_q, pc_seq, pc_tgt, pc_next;
  logic [XLEN-1:0] inst, imm, rs1_v, rs2_v, op_b, alu_y, ld_data, wb_data;
  ctl_t            ctl;
  alu_fn_e         fn;
  logic            zero, lt, take;
  logic [RW-1:0]   rs1, rs2, rd;
  logic [2:0]      f3;
  logic [AW-1:0]   fetch_idx, data_idx;
  logic            data_we;
  logic [XLEN-1:0] data_wr;

  assign rs1 = inst[19:15];
  assign rs2 = inst[24:20];
  assign rd  = inst[11:7];
  assign f3  = inst[14:12];

  sc_decode u_dec (
    .inst (inst),
    .ctl  (ctl),
    .fn   (fn),
    .imm  (imm)
  );

  sc_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk (clk),
    .rst (rst),
    .we  (ctl.reg_we && !rst),
    .wa  (rd),
    .wd  (wb_data),
    .ra1 (rs1),
    .ra2 (rs2),
    .rd1 (rs1_v),
    .rd2 (rs2_v)
  );

  assign op_b = ctl.use_imm ? imm : rs2_v;

  sc_alu u_alu (
    .a  (rs1_v),
    .b  (op_b),
    .fn (fn),
    .y  (alu_y)
  );

  // branch decision from the ALU difference; overflow-safe signed less-than
  assign zero = (alu_y == '0);
  assign lt   = (rs1_v[XLEN-1] ^ rs2_v[XLEN-1]) ? rs1_v[XLEN-1] : alu_y[XLEN-1];

  always_comb begin
    case (f3)
      3'b000:  take = zero;
      3'b001:  take = !zero;
      3'b100:  take = lt;
      3'b101:  take = !lt;
      default: take = 1'b0;
    endcase
    take = take && ctl.is_branch;
  end

  assign pc_seq  = pc_q + XLEN'(4);
  assign pc_tgt  = pc_q + imm;
  assign pc_next = take ? pc_tgt : pc_seq;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  // fetch reads the word the PC moves to, so instruction and PC change together
  assign fetch_idx = rst ? '0 : pc_next[AW+1:2];

  // data port: preload owns it in reset, the core owns it otherwise
  assign data_idx = rst ? load_addr : alu_y[AW+1:2];
  assign data_we  = rst ? load_en   : ctl.mem_we;
  assign data_wr  = rst ? load_data : rs2_v;

  sc_mem #(.AW(AW), .W(XLEN)) u_mem (
    .clk     (clk),
    .a_addr  (fetch_idx),
    .a_rdata (inst),
    .b_addr  (data_idx),
    .b_we    (data_we),
    .b_wdata (data_wr),
    .b_rdata (ld_data)
  );

  assign wb_data = ctl.wb_from_mem ? ld_data : alu_y;

  assign pc_o      = pc_q;
  assign wb_en_o   = ctl.reg_we && (rd != '0) && !rst;
  assign wb_rd_o   = rd;
  assign wb_data_o = wb_data;

  p_reset_pc_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pc_q == '0);

  p_seq_pc_r9: assert property (@(posedge clk) disable iff (rst)
    !ctl.is_branch |=> pc_q == $past(pc_q) + XLEN'(4));

  p_taken_pc_r8: assert property (@(posedge clk) disable iff (rst)
    (ctl.is_branch && take) |=> pc_q == $past(pc_q + imm));
endmodule

// File: tb/sim_sc_core.sv
`timescale 1ns/1ps
module sim_sc_core;
  localparam int AW = 10;
  localparam int NSTEP = 29;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_en = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [31:0]   load_data = '0;
  logic [31:0]   pc_o, wb_data_o;
  logic          wb_en_o;
  logic [4:0]    wb_rd_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  sc_core #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .pc_o(pc_o), .wb_en_o(wb_en_o),
    .wb_rd_o(wb_rd_o), .wb_data_o(wb_data_o)
  );

  function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] b, logic [4:0] a,
                                        logic [2:0] f3, logic [4:0] d);
    return {f7, b, a, f3, d, 7'b0110011};
  endfunction
  function automatic logic [31:0] enc_i(logic [11:0] im, logic [4:0] a, logic [2:0] f3,
                                        logic [4:0] d);
    return {im, a, f3, d, 7'b0010011};
  endfunction
  function automatic logic [31:0] enc_l(logic [11:0] im, logic [4:0] a, logic [4:0] d);
    return {im, a, 3'b010, d, 7'b0000011};
  endfunction
  function automatic logic [31:0] enc_s(logic [11:0] im, logic [4:0] b, logic [4:0] a);
    return {im[11:5], b, a, 3'b010, im[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] enc_b(logic [12:0] im, logic [4:0] b, logic [4:0] a,
                                        logic [2:0] f3);
    return {im[12], im[10:5], b, a, f3, im[4:1], im[11], 7'b1100011};
  endfunction

  // program, word index = byte address / 4
  localparam logic [31:0] PROG [32] = '{
    enc_i(12'd5, 5'd0, 3'd0, 5'd1),          // 0   addi x1,x0,5
    enc_i(12'hFFD, 5'd0, 3'd0, 5'd2),        // 4   addi x2,x0,-3
    enc_r(7'h00, 5'd2, 5'd1, 3'd0, 5'd3),    // 8   add x3,x1,x2
    enc_r(7'h20, 5'd1, 5'd2, 3'd0, 5'd4),    // 12  sub x4,x2,x1
    enc_r(7'h00, 5'd1, 5'd2, 3'd2, 5'd5),    // 16  slt x5,x2,x1
    enc_r(7'h00, 5'd1, 5'd2, 3'd3, 5'd6),    // 20  sltu x6,x2,x1
    enc_r(7'h00, 5'd2, 5'd1, 3'd4, 5'd7),    // 24  xor x7,x1,x2
    enc_r(7'h20, 5'd3, 5'd4, 3'd5, 5'd8),    // 28  sra x8,x4,x3
    enc_r(7'h00, 5'd3, 5'd4, 3'd5, 5'd9),    // 32  srl x9,x4,x3
    enc_r(7'h00, 5'd3, 5'd1, 3'd1, 5'd10),   // 36  sll x10,x1,x3
    enc_r(7'h00, 5'd3, 5'd1, 3'd6, 5'd11),   // 40  or x11,x1,x3
    enc_r(7'h00, 5'd1, 5'd2, 3'd7, 5'd12),   // 44  and x12,x2,x1
    enc_i(12'h401, 5'd2, 3'd5, 5'd13),       // 48  srai x13,x2,1
    enc_i(12'd7, 5'd1, 3'd0, 5'd0),          // 52  addi x0,x1,7
    enc_r(7'h00, 5'd1, 5'd0, 3'd0, 5'd14),   // 56  add x14,x0,x1
    enc_s(12'h100, 5'd4, 5'd0),              // 60  sw x4,0x100(x0)
    enc_i(12'd10, 5'd1, 3'd1, 5'd15),        // 64  slli x15,x1,10
    enc_s(12'h000, 5'd3, 5'd15),             // 68  sw x3,0(x15)
    enc_l(12'h400, 5'd0, 5'd16),             // 72  lw x16,0x400(x0)
    enc_l(12'h100, 5'd0, 5'd17),             // 76  lw x17,0x100(x0)
    enc_r(7'h00, 5'd1, 5'd17, 3'd0, 5'd18),  // 80  add x18,x17,x1
    enc_b(13'd8, 5'd1, 5'd1, 3'd0),          // 84  beq x1,x1,+8
    enc_i(12'd1, 5'd0, 3'd0, 5'd19),         // 88  skipped
    enc_b(13'd8, 5'd1, 5'd1, 3'd1),          // 92  bne x1,x1,+8
    enc_b(13'd8, 5'd1, 5'd2, 3'd4),          // 96  blt x2,x1,+8
    enc_i(12'd2, 5'd0, 3'd0, 5'd19),         // 100 skipped
    enc_b(13'd8, 5'd1, 5'd2, 3'd5),          // 104 bge x2,x1,+8
    enc_b(13'd8, 5'd2, 5'd1, 3'd5),          // 108 bge x1,x2,+8
    enc_i(12'd3, 5'd0, 3'd0, 5'd19),         // 112 skipped
    32'h0000_0000,                           // 116 unknown opcode
    enc_b(13'd8, 5'd2, 5'd1, 3'd4),          // 120 blt x1,x2,+8
    enc_b(13'd0, 5'd0, 5'd0, 3'd0)           // 124 beq x0,x0,0
  };

  // {req, pc, wb_en, rd, data}; rd/data compared only when wb_en is expected
  localparam logic [73:0] TRACE [NSTEP] = '{
    {4'd3,  32'd0,   1'b1, 5'd1,  32'd5},         // R3 addi
    {4'd3,  32'd4,   1'b1, 5'd2,  32'hFFFFFFFD},  // R3 negative immediate
    {4'd2,  32'd8,   1'b1, 5'd3,  32'd2},         // R2 add
    {4'd2,  32'd12,  1'b1, 5'd4,  32'hFFFFFFF8},  // R2 sub
    {4'd2,  32'd16,  1'b1, 5'd5,  32'd1},         // R2 slt signed
    {4'd2,  32'd20,  1'b1, 5'd6,  32'd0},         // R2 sltu unsigned
    {4'd2,  32'd24,  1'b1, 5'd7,  32'hFFFFFFF8},  // R2 xor
    {4'd2,  32'd28,  1'b1, 5'd8,  32'hFFFFFFFE},  // R2 sra
    {4'd2,  32'd32,  1'b1, 5'd9,  32'h3FFFFFFE},  // R2 srl
    {4'd2,  32'd36,  1'b1, 5'd10, 32'h14},        // R2 sll
    {4'd2,  32'd40,  1'b1, 5'd11, 32'd7},         // R2 or
    {4'd2,  32'd44,  1'b1, 5'd12, 32'd5},         // R2 and
    {4'd3,  32'd48,  1'b1, 5'd13, 32'hFFFFFFFE},  // R3 srai
    {4'd4,  32'd52,  1'b0, 5'd0,  32'd0},         // R4 write to x0 dropped
    {4'd4,  32'd56,  1'b1, 5'd14, 32'd5},         // R4 x0 reads zero
    {4'd6,  32'd60,  1'b0, 5'd0,  32'd0},         // R6 store, no writeback
    {4'd7,  32'd64,  1'b1, 5'd15, 32'h1400},      // R7 high address
    {4'd7,  32'd68,  1'b0, 5'd0,  32'd0},         // R7 store to aliased word
    {4'd7,  32'd72,  1'b1, 5'd16, 32'd2},         // R7 alias read back
    {4'd5,  32'd76,  1'b1, 5'd17, 32'hFFFFFFF8},  // R5 load of stored word
    {4'd12, 32'd80,  1'b1, 5'd18, 32'hFFFFFFFD},  // R12 use right after load
    {4'd8,  32'd84,  1'b0, 5'd0,  32'd0},         // R8 beq taken
    {4'd9,  32'd92,  1'b0, 5'd0,  32'd0},         // R9 bne not taken
    {4'd8,  32'd96,  1'b0, 5'd0,  32'd0},         // R8 blt taken
    {4'd9,  32'd104, 1'b0, 5'd0,  32'd0},         // R9 bge not taken
    {4'd8,  32'd108, 1'b0, 5'd0,  32'd0},         // R8 bge taken
    {4'd10, 32'd116, 1'b0, 5'd0,  32'd0},         // R10 unknown opcode
    {4'd9,  32'd120, 1'b0, 5'd0,  32'd0},         // R9 signed blt not taken
    {4'd8,  32'd124, 1'b0, 5'd0,  32'd0}          // R8 self-loop
  };

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic put_word(logic [AW-1:0] a, logic [31:0] d);
    @(posedge clk); #1;
    load_en = 1'b1; load_addr = a; load_data = d;
  endtask

  task automatic leave_reset();
    @(posedge clk); #1;
    load_en = 1'b0;
    @(posedge clk);
    @(posedge clk); #1;
    rst = 1'b0;
  endtask

  initial begin
    // phase 1: preload in reset (R11) and check the reset state (R1)
    for (int k = 0; k < 32; k++) put_word(AW'(k), PROG[k]);
    #5;
    chk("R1", "pc in reset", pc_o, 32'd0);
    chk("R1", "no write in reset", {31'd0, wb_en_o}, 32'd0);
    leave_reset();

    // phase 1: walk the trace table
    for (int s = 0; s < NSTEP; s++) begin
      #15;
      begin
        logic [73:0] v;
        string tag;
        v = TRACE[s];
        tag = $sformatf("R%0d", v[73:70]);
        chk(tag, $sformatf("step %0d pc", s), pc_o, v[69:38]);
        chk(tag, $sformatf("step %0d wb_en", s), {31'd0, wb_en_o}, {31'd0, v[37]});
        if (v[37]) begin
          chk(tag, $sformatf("step %0d rd", s), {27'd0, wb_rd_o}, {27'd0, v[36:32]});
          chk(tag, $sformatf("step %0d data", s), wb_data_o, v[31:0]);
        end
      end
      @(posedge clk); #1;
    end

    // phase 2: reset clears registers (R1), memory keeps stored data (R5),
    // preload port ignored outside reset (R11)
    rst = 1'b1;
    put_word(AW'(0), enc_r(7'h00, 5'd2, 5'd1, 3'd0, 5'd20));   // add x20,x1,x2
    put_word(AW'(1), enc_r(7'h00, 5'd16, 5'd17, 3'd0, 5'd21)); // add x21,x17,x16
    put_word(AW'(2), enc_l(12'h100, 5'd0, 5'd22));             // lw x22,0x100(x0)
    put_word(AW'(3), enc_i(12'd1, 5'd0, 3'd0, 5'd23));         // addi x23,x0,1
    put_word(AW'(4), enc_b(13'd0, 5'd0, 5'd0, 3'd0));          // beq x0,x0,0
    leave_reset();

    #15;
    chk("R1", "pc after reset", pc_o, 32'd0);
    chk("R1", "x1+x2 after reset", wb_data_o, 32'd0);
    @(posedge clk); #1;
    // attempt to overwrite word 3 while running
    load_en = 1'b1; load_addr = AW'(3); load_data = enc_i(12'd9, 5'd0, 3'd0, 5'd23);
    #15;
    chk("R1", "x17+x16 after reset", wb_data_o, 32'd0);
    @(posedge clk); #1;
    load_en = 1'b0;
    #15;
    chk("R5", "lw after reset", wb_data_o, 32'hFFFFFFF8);
    @(posedge clk); #1;
    #15;
    chk("R11", "preload ignored outside reset", wb_data_o, 32'd1);
    chk("R11", "pc at word 3", pc_o, 32'd12);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule